// File: doc/BRIEF.md
# Frame Sequencer with Interrupt Flag

This block is the timing backbone of a sound-generation unit. It divides the CPU-rate clock into fixed-length steps. On each step it emits a quarter-frame pulse, and on selected steps it also emits a half-frame pulse. The sound channels that consume these pulses sit outside the block. Two sequence lengths are available: a 4-step sequence and a 5-step sequence.

In the 4-step sequence, the block raises an interrupt flag when the last step completes. The interrupt line is a level. It is high whenever the flag is set and the inhibit bit is clear, and it stays high until software clears the flag. Software clears the flag in one of two ways:
- reading the status register, which acknowledges the interrupt;
- writing the control register with the inhibit bit set.

The control write also selects the sequence length and restarts the sequence at its first step. In 5-step mode the control write additionally fires one immediate quarter-frame and half-frame pulse. Status bits that belong to the sound channels are outside this block and read as zero.

Top module: `frame_seq`

## Requirements
- R1: A synchronous active-low reset selects 4-step mode and clears both the inhibit bit and the flag. After reset, `irq` is low, no pulse is produced, and the first step is counted from the first cycle after reset is released.
- R2: `qtr_pulse` is high for exactly one cycle at the end of each step. A step lasts STEP_CLKS cycles, counted from reset release or from a control write. The first pulse comes in the STEP_CLKS-th cycle.
- R3: `half_pulse` is high only together with `qtr_pulse`. In 4-step mode it fires at the end of steps 2 and 4. In 5-step mode it fires at the end of steps 2 and 5.
- R4: In 4-step mode, the flag is set at the end of step 4, and `irq` rises in the following cycle. The sequence then repeats from step 1.
- R5: 5-step mode never sets the flag.
- R6: `irq` is a level equal to the flag gated by the inhibit bit. It is not a one-cycle event. While the flag is set and inhibit is 0, it stays high until the flag is cleared.
- R7: Reading address 0x4015 (`bus_rd` high for one cycle) returns the flag on bit 6 of `bus_rdata` in the next cycle, with all other bits 0. A read at any other address returns 0 and leaves the flag unchanged.
- R8: A status read clears the flag after its value is captured, so the read that sees the flag still returns bit 6 = 1 and the next read returns 0. If the flag is being set in the same cycle as the read, the set wins and the flag stays 1.
- R9: Writing address 0x4017 loads the mode from bit 7 (0 = 4-step, 1 = 5-step) and the inhibit bit from bit 6. The write restarts the sequence at step 1, and no step-end event occurs in the write cycle.
- R10: A control write with bit 6 = 1 clears the flag, so `irq` is low in the next cycle. The flag stays clear after inhibit is later removed.
- R11: A control write that selects 5-step mode produces one `qtr_pulse` and one `half_pulse` in the next cycle. A write that selects 4-step mode produces no such pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| qtr_pulse | output | 1 | Quarter-frame pulse |
| half_pulse | output | 1 | Half-frame pulse |
| irq | output | 1 | Level interrupt request, active high |

## Verification
A wrong step counter shows up as quarter-frame pulses spaced differently from STEP_CLKS, or as half-frame pulses on the wrong steps. This is visible within one step length. It also shows up as a rising `irq` earlier or later than the fourth step end, which is visible within four step lengths.

A flag that is not cleared, or is cleared too early, appears on the very next status read. If the read clears the flag before capturing it, that read returns 0. A flag that is not cleared shows up because the following read still returns 0x40 or `irq` stays high. The bench measures pulse counts over whole sequences and probes each of these exact boundary cycles.

// File: rtl/fseq_pkg.sv
// Shared definitions for the frame sequencer: register addresses, bit
// positions and the sequence-length encoding.
package fseq_pkg;
    typedef enum logic {
        SEQ_FOUR = 1'b0,
        SEQ_FIVE = 1'b1
    } seq_mode_e;

    localparam logic [15:0] STATUS_ADDR = 16'h4015;
    localparam logic [15:0] CTRL_ADDR   = 16'h4017;
    localparam int          MODE_BIT    = 7;
    localparam int          INHIBIT_BIT = 6;
    localparam int          FLAG_BIT    = 6;
    localparam int          STEP_W      = 3;
endpackage

// File: rtl/fseq_divider.sv
// Step divider. It counts STEP_CLKS clocks per step and walks the step
// index through 4 or 5 steps.
// Assumes: restart has priority over counting, and no step end is reported
// in a restart cycle.
module fseq_divider #(
    parameter int STEP_CLKS = 3729
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      five_step,
    output logic                      step_end,
    output logic                      at_half_step,
    output logic                      at_last_step
);
    import fseq_pkg::*;

    localparam int DIV_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_CLKS - 1);

    logic [DIV_W-1:0]  div_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] last_idx;
    logic              div_wrap;

    assign last_idx     = five_step ? STEP_W'(4) : STEP_W'(3);
    assign div_wrap     = (div_q == DIV_LAST);
    assign step_end     = div_wrap && !restart;
    assign at_last_step = (step_q == last_idx);
    assign at_half_step = (step_q == STEP_W'(1)) || at_last_step;

    // Clock divider and step index, both restarted by reset or a control write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q  <= '0;
            step_q <= '0;
        end else if (div_wrap) begin
            div_q  <= '0;
            step_q <= at_last_step ? '0 : step_q + STEP_W'(1);
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // R3
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= STEP_W'(4));

    generate
        if (STEP_CLKS > 1) begin : g_gap
            // R2
            step_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                step_end |=> !step_end);
        end
    endgenerate
endmodule

// File: rtl/fseq_irqflag.sv
// Frame interrupt flag. Set on the last step of the 4-step sequence,
// cleared by an inhibit write or a status read.
// Assumes: a status read clears the flag at the same edge that captures it.
module fseq_irqflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic inhibit_wr,
    input  logic status_rd,
    output logic flag
);
    logic flag_q;

    // Flag update. Inhibit write first, then the set event, then the read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (inhibit_wr)
            flag_q <= 1'b0;
        else if (set_evt)
            flag_q <= 1'b1;
        else if (status_rd)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !inhibit_wr) |=> flag_q);
    // R8
    read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !set_evt) |=> !flag_q);
    // R10
    inhibit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_wr |=> !flag_q);
endmodule

// File: rtl/frame_seq.sv
// Frame sequencer top. Holds the control register, decodes bus accesses,
// forms the quarter- and half-frame pulses and drives the level IRQ.
// Assumes: strobes last one cycle, and read data is registered for one cycle.
module frame_seq #(
    parameter int STEP_CLKS = 3729
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic        qtr_pulse,
    output logic        half_pulse,
    output logic        irq
);
    import fseq_pkg::*;

    seq_mode_e mode_q;
    logic      inhibit_q;
    logic      kick_q;
    logic      ctrl_wr;
    logic      status_rd;
    logic      step_end;
    logic      at_half_step;
    logic      at_last_step;
    logic      flag;
    logic      set_evt;
    logic [7:0] rdata_q;

    assign ctrl_wr   = bus_wr && (bus_addr == CTRL_ADDR);
    assign status_rd = bus_rd && (bus_addr == STATUS_ADDR);

    fseq_divider #(.STEP_CLKS(STEP_CLKS)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (ctrl_wr),
        .five_step    (mode_q == SEQ_FIVE),
        .step_end     (step_end),
        .at_half_step (at_half_step),
        .at_last_step (at_last_step)
    );

    assign set_evt = step_end && at_last_step && (mode_q == SEQ_FOUR);

    fseq_irqflag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_evt    (set_evt),
        .inhibit_wr (ctrl_wr && bus_wdata[INHIBIT_BIT]),
        .status_rd  (status_rd),
        .flag       (flag)
    );

    // Control register: sequence length, inhibit bit and the 5-step kick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= SEQ_FOUR;
            inhibit_q <= 1'b0;
            kick_q    <= 1'b0;
        end else begin
            kick_q <= ctrl_wr && bus_wdata[MODE_BIT];
            if (ctrl_wr) begin
                mode_q    <= seq_mode_e'(bus_wdata[MODE_BIT]);
                inhibit_q <= bus_wdata[INHIBIT_BIT];
            end
        end
    end

    // Read data register: captures the flag before the acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (status_rd)
            rdata_q <= 8'(flag) << FLAG_BIT;
        else
            rdata_q <= '0;
    end

    assign bus_rdata  = rdata_q;
    assign qtr_pulse  = step_end || kick_q;
    assign half_pulse = (step_end && at_half_step) || kick_q;
    assign irq        = flag && !inhibit_q;

    // R5
    five_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEQ_FIVE && !flag) |=> !flag);
    // R3
    half_with_qtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse |-> qtr_pulse);
    // R11
    kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[MODE_BIT]) |=> (qtr_pulse && half_pulse));
    // R7
    rdata_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & 8'hBF) == 8'h00);
endmodule

// File: tb/frame_seq_test.sv
module frame_seq_test;
    localparam int STEP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        qtr_pulse, half_pulse, irq;

    int n_checks = 0;
    int n_fail = 0;
    int qc, hc;
    logic [7:0] rd_val;

    frame_seq #(.STEP_CLKS(STEP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .qtr_pulse(qtr_pulse), .half_pulse(half_pulse), .irq(irq)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] cycles;
        logic [3:0] exp_q;
        logic [3:0] exp_h;
        logic       exp_irq;
        logic [7:0] exp_st;
    } vec_t;

    // 5-step runs include the kick pulse at the first sampled cycle.
    localparam vec_t VECS [6] = '{
        '{8'h00, 8'd32, 4'd4, 4'd2, 1'b1, 8'h40},
        '{8'h40, 8'd32, 4'd4, 4'd2, 1'b0, 8'h40},
        '{8'h80, 8'd40, 4'd6, 4'd3, 1'b0, 8'h00},
        '{8'h00, 8'd31, 4'd3, 4'd1, 1'b0, 8'h00},
        '{8'hC0, 8'd40, 4'd6, 4'd3, 1'b0, 8'h00},
        '{8'h00, 8'd64, 4'd8, 4'd4, 1'b1, 8'h40}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        bus_addr = 16'h4017; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic count(input int n);
        qc = 0; hc = 0;
        for (int k = 0; k < n; k++) begin
            if (qtr_pulse) qc++;
            if (half_pulse) hc++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 rdata", int'(bus_rdata), 0);
        chk("R1 qtr", int'(qtr_pulse), 0);
        rst_n = 1'b1;
        // R1/R4: default 4-step, irq enabled
        count(32);
        chk("R1 qtr count", qc, 4);
        chk("R1 half count", hc, 2);
        chk("R4 irq after step4", int'(irq), 1);
        // R7: other address reads 0 and does not ack
        do_read(16'h4016, rd_val);
        chk("R7 other addr", int'(rd_val), 0);
        chk("R6 irq held", int'(irq), 1);
        // R7/R8: read sees flag, next read is 0
        do_read(16'h4015, rd_val);
        chk("R7 status bit6", int'(rd_val), 8'h40);
        chk("R8 irq cleared", int'(irq), 0);
        do_read(16'h4015, rd_val);
        chk("R8 second read", int'(rd_val), 0);

        // Vector table
        foreach (VECS[i]) begin
            do_read(16'h4015, rd_val);
            do_write(VECS[i].ctrl);
            count(int'(VECS[i].cycles));
            chk("R2 qtr count", qc, int'(VECS[i].exp_q));
            chk("R3 half count", hc, int'(VECS[i].exp_h));
            chk("R6 irq level", int'(irq), int'(VECS[i].exp_irq));
            do_read(16'h4015, rd_val);
            chk("R5 R8 status", int'(rd_val), int'(VECS[i].exp_st));
        end

        // R10: inhibit write clears flag
        do_read(16'h4015, rd_val);
        do_write(8'h00);
        count(33);
        chk("R4 irq", int'(irq), 1);
        do_write(8'h40);
        chk("R10 irq low", int'(irq), 0);
        do_write(8'h00);
        chk("R10 flag stays clear", int'(irq), 0);
        do_read(16'h4015, rd_val);
        chk("R10 status", int'(rd_val), 0);

        // R9: restart mid-step, first pulse exactly STEP cycles later
        count(20);
        do_write(8'h00);
        chk("R11 no kick in 4-step", int'(qtr_pulse), 0);
        count(STEP - 1);
        chk("R9 no early pulse", qc, 0);
        chk("R9 pulse at step end", int'(qtr_pulse), 1);
        chk("R3 step1 no half", int'(half_pulse), 0);

        // R11: 5-step kick
        do_write(8'h80);
        chk("R11 kick qtr", int'(qtr_pulse), 1);
        chk("R11 kick half", int'(half_pulse), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule